// File: doc/BRIEF.md
# Register-Indirect Call With Instruction-Set Switch

This unit decodes and executes one instruction: a call through a general-purpose register, which may also switch the processor between two instruction sets. In wide mode, instructions are 32-bit words. In compact mode, they are 16-bit halfwords, carried in the low half of the instruction input.

When a call is accepted and its condition passes, four things happen together:

- the unit computes a return address for the link register;
- it loads the program counter from the register value with bit 0 cleared;
- it takes the new mode from bit 0 of that value (0 selects wide, 1 selects compact);
- it flags encodings whose result is not defined.

The unit holds the program counter (PC) and the mode. Both change only on a clock edge where a handled instruction is presented with a passing condition.

The register file is outside the block. The unit puts the register index on `rf_addr_o` and expects the value back on `rf_data_i` in the same cycle. The condition is evaluated outside the block and arrives as a single pass/fail bit. The status of the surrounding predicated group also arrives from outside.

Top module: `indcall_exchange_unit`

## Requirements
- R1: After a synchronous active-low reset, `pc_o` is 0 and `mode_o` is 0 (wide).
- R2: In wide mode, a word is handled when bits [27:20] = 8'h12, bits [7:4] = 4'h3 and bits [31:28] are not 4'hF. The register index is bits [3:0].
- R3: In compact mode, a halfword is handled when bits [15:7] = 9'b010001111. The register index is bits [6:3], and bits [31:16] are ignored.
- R4: A taken call loads `pc_o` with `rf_data_i` with bit 0 cleared, and loads `mode_o` with `rf_data_i[0]`. The value presented on `next_pc_o` is the value `pc_o` takes at the following edge.
- R5: A taken call in wide mode drives `lr_data_o` = `pc_o` + 4, with `lr_we_o` high.
- R6: A taken call in compact mode drives `lr_data_o` = (`pc_o` + 2) with bit 0 set, with `lr_we_o` high.
- R7: When `cond_pass_i` is low or `valid_i` is low, `lr_we_o` stays low and `pc_o` and `mode_o` keep their values.
- R8: A handled instruction whose register index is 15 raises `unpred_o`.
- R9: A handled compact instruction raises `unpred_o` when `grp_inside_i` is high and `grp_last_i` is low.
- R10: A handled wide instruction whose target has bits [1:0] = 2'b10 raises `unpred_o`.
- R11: A handled instruction raises `unpred_o` in two further cases: a wide word with any of bits [19:8] clear, or a compact halfword with any of bits [2:0] set. The call still executes.
- R12: With `valid_i` high, a word that does not match the current mode's encoding raises `nothandled_o`. It has no effect on `pc_o`, `mode_o` or `lr_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word; compact mode uses [15:0] |
| cond_pass_i | input | 1 | Condition result from outside |
| grp_inside_i | input | 1 | Instruction lies in a predicated group |
| grp_last_i | input | 1 | Instruction is the last of that group |
| rf_addr_o | output | 4 | Register index for the read port |
| rf_data_i | input | 32 | Value read from the register file |
| pc_o | output | 32 | Address of the current instruction |
| mode_o | output | 1 | Current mode, 0 wide, 1 compact |
| next_pc_o | output | 32 | PC after this cycle's edge |
| lr_we_o | output | 1 | Link register write enable |
| lr_data_o | output | 32 | Return address to write |
| unpred_o | output | 1 | Result of the instruction is not defined |
| nothandled_o | output | 1 | Word is not a call of the current mode |

## Verification
The assertions assume two things about the inputs:

- `rf_data_i` is a settled function of the cycle, so its value can be compared one edge later against the loaded PC.
- `cond_pass_i` and the group status are meaningful only while `valid_i` is high.

The stimulus drives every input at the falling edge and holds it through the rising edge. The encodings it generates follow whichever mode the bench's own model says the unit is in, so both decode paths and mode switches in both directions are exercised. It mixes clean encodings, deliberately damaged fixed-value fields and fully random words. Register index 15, misaligned wide targets and group positions are drawn at set rates.

// File: rtl/icx_pkg.sv
// Package: shared constants and types for the register-indirect call unit.
// Assumes: a 32-bit datapath and 16 architectural registers.
package icx_pkg;
    localparam int unsigned XLEN    = 32;
    localparam int unsigned RIDX_W  = 4;

    // mode encoding carried on mode_o and in the state register
    typedef enum logic {
        MODE_WIDE    = 1'b0,
        MODE_COMPACT = 1'b1
    } isa_mode_e;

    // fixed fields of the wide encoding
    localparam logic [7:0]  WIDE_OPC_MID  = 8'h12;
    localparam logic [3:0]  WIDE_OPC_LOW  = 4'h3;
    localparam logic [3:0]  WIDE_COND_NV  = 4'hF;
    localparam logic [11:0] WIDE_SBO      = 12'hFFF;
    // fixed fields of the compact encoding
    localparam logic [8:0]  CMP_OPC       = 9'b010001111;
    localparam logic [2:0]  CMP_SBZ       = 3'b000;
    // register whose use is undefined as a call target
    localparam logic [RIDX_W-1:0] PC_REG_IDX = 4'd15;

    // decoded view of one instruction word
    typedef struct packed {
        logic              hit;
        logic [RIDX_W-1:0] rm;
        logic              shape_bad;
    } dec_t;
endpackage

// File: rtl/icx_decode.sv
// Module: icx_decode
// Matches the instruction word against the encoding of the current mode,
// extracts the register index and reports damaged fixed-value fields.
// Assumes: compact halfwords are carried in bits [15:0].
module icx_decode
    import icx_pkg::*;
#(
    parameter int unsigned IW = 32
) (
    input  logic [IW-1:0] instr,
    input  isa_mode_e     mode,
    output dec_t          dec
);
    dec_t wide_d;
    dec_t cmp_d;

    // wide-encoding field match
    always_comb begin
        wide_d.hit       = (instr[27:20] == WIDE_OPC_MID) &&
                           (instr[7:4]   == WIDE_OPC_LOW) &&
                           (instr[31:28] != WIDE_COND_NV);
        wide_d.rm        = instr[3:0];
        wide_d.shape_bad = (instr[19:8] != WIDE_SBO);
    end

    // compact-encoding field match
    always_comb begin
        cmp_d.hit       = (instr[15:7] == CMP_OPC);
        cmp_d.rm        = instr[6:3];
        cmp_d.shape_bad = (instr[2:0] != CMP_SBZ);
    end

    // pick the view belonging to the current mode
    always_comb begin
        dec = (mode == MODE_COMPACT) ? cmp_d : wide_d;
    end
endmodule

// File: rtl/icx_link.sv
// Module: icx_link
// Forms the return address of a call from the current instruction address.
// Assumes: the address of the next instruction is pc+4 (wide) or pc+2 (compact).
module icx_link
    import icx_pkg::*;
#(
    parameter int unsigned W = XLEN
) (
    input  logic [W-1:0] pc,
    input  isa_mode_e    mode,
    output logic [W-1:0] link
);
    localparam logic [W-1:0] WIDE_STEP = W'(4);
    localparam logic [W-1:0] CMP_STEP  = W'(2);

    logic [W-1:0] seq_addr;

    // sequential address, with bit 0 marking compact callers
    always_comb begin
        if (mode == MODE_COMPACT) begin
            seq_addr = pc + CMP_STEP;
            link     = {seq_addr[W-1:1], 1'b1};
        end else begin
            seq_addr = pc + WIDE_STEP;
            link     = seq_addr;
        end
    end
endmodule

// File: rtl/icx_hazard.sv
// Module: icx_hazard
// Raises the flag for handled calls whose outcome is not defined.
// Assumes: dec comes from icx_decode for the same cycle.
module icx_hazard
    import icx_pkg::*;
#(
    parameter int unsigned W = XLEN
) (
    input  logic      valid,
    input  dec_t      dec,
    input  isa_mode_e mode,
    input  logic      grp_inside,
    input  logic      grp_last,
    input  logic [1:0] tgt_low,
    output logic      unpred
);
    logic bad_reg;
    logic bad_grp;
    logic bad_align;

    // individual undefined cases
    always_comb begin
        bad_reg   = (dec.rm == PC_REG_IDX);
        bad_grp   = (mode == MODE_COMPACT) && grp_inside && !grp_last;
        bad_align = (mode == MODE_WIDE) && (tgt_low == 2'b10);
        unpred    = valid && dec.hit &&
                    (bad_reg || bad_grp || bad_align || dec.shape_bad);
    end
endmodule

// File: rtl/icx_state.sv
// Module: icx_state
// Holds the instruction address and mode; loads both on a taken call.
// Assumes: target bit 0 selects the mode and is never part of the address.
module icx_state
    import icx_pkg::*;
#(
    parameter int unsigned   W      = XLEN,
    parameter logic [W-1:0]  PC_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] target,
    output logic [W-1:0] pc_q,
    output isa_mode_e    mode_q
);
    // address and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= PC_RST;
            mode_q <= MODE_WIDE;
        end else if (take) begin
            pc_q   <= {target[W-1:1], 1'b0};
            mode_q <= isa_mode_e'(target[0]);
        end
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(pc_q) && $stable(mode_q))); // R7
    AST_MODE_FROM_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (mode_q == isa_mode_e'($past(target[0])))); // R4
    AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (pc_q[0] == 1'b0)); // R4
endmodule

// File: rtl/indcall_exchange_unit.sv
// Module: indcall_exchange_unit
// Executes a call through a register, optionally switching instruction set.
// Assumes: condition evaluation and register read are done outside, same cycle.
module indcall_exchange_unit
    import icx_pkg::*;
#(
    parameter int unsigned      W      = XLEN,
    parameter logic [W-1:0]     PC_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [31:0]       instr_i,
    input  logic              cond_pass_i,
    input  logic              grp_inside_i,
    input  logic              grp_last_i,
    output logic [RIDX_W-1:0] rf_addr_o,
    input  logic [W-1:0]      rf_data_i,
    output logic [W-1:0]      pc_o,
    output logic              mode_o,
    output logic [W-1:0]      next_pc_o,
    output logic              lr_we_o,
    output logic [W-1:0]      lr_data_o,
    output logic              unpred_o,
    output logic              nothandled_o
);
    dec_t         dec;
    isa_mode_e    mode_q;
    logic [W-1:0] pc_q;
    logic [W-1:0] link;
    logic         take;

    icx_decode #(.IW(32)) u_decode (
        .instr (instr_i),
        .mode  (mode_q),
        .dec   (dec)
    );

    icx_link #(.W(W)) u_link (
        .pc   (pc_q),
        .mode (mode_q),
        .link (link)
    );

    icx_hazard #(.W(W)) u_hazard (
        .valid      (valid_i),
        .dec        (dec),
        .mode       (mode_q),
        .grp_inside (grp_inside_i),
        .grp_last   (grp_last_i),
        .tgt_low    (rf_data_i[1:0]),
        .unpred     (unpred_o)
    );

    icx_state #(.W(W), .PC_RST(PC_RST)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .target (rf_data_i),
        .pc_q   (pc_q),
        .mode_q (mode_q)
    );

    // accept decision and port outputs
    always_comb begin
        take         = valid_i && dec.hit && cond_pass_i;
        rf_addr_o    = dec.rm;
        pc_o         = pc_q;
        mode_o       = mode_q;
        lr_we_o      = take;
        lr_data_o    = link;
        next_pc_o    = take ? {rf_data_i[W-1:1], 1'b0} : pc_q;
        nothandled_o = valid_i && !dec.hit;
    end

    AST_NO_LINK_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond_pass_i || !valid_i) |-> !lr_we_o); // R7
    AST_NEXT_PC_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we_o |=> (pc_o == $past(next_pc_o))); // R4
    AST_REG15_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !nothandled_o && rf_addr_o == PC_REG_IDX) |-> unpred_o); // R8
    AST_COMPACT_LINK_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_we_o && mode_o) |-> lr_data_o[0]); // R6
    AST_WIDE_LINK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_we_o && !mode_o) |-> (lr_data_o - pc_o == W'(4))); // R5
    AST_UNHANDLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        nothandled_o |-> (!lr_we_o && !unpred_o)); // R12
endmodule

// File: tb/tb_indcall_exchange_unit.sv
module tb_indcall_exchange_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic        cond_pass_i = 1'b0;
    logic        grp_inside_i = 1'b0;
    logic        grp_last_i = 1'b0;
    logic [3:0]  rf_addr_o;
    logic [31:0] rf_data_i = '0;
    logic [31:0] pc_o;
    logic        mode_o;
    logic [31:0] next_pc_o;
    logic        lr_we_o;
    logic [31:0] lr_data_o;
    logic        unpred_o;
    logic        nothandled_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_pc = '0;
    logic        m_mode = 1'b0;

    always #5 clk = ~clk;

    indcall_exchange_unit dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wide_word(input logic [3:0] cnd, input logic [3:0] rm, input logic dmg);
        return {cnd, 8'h12, (dmg ? 12'hF7F : 12'hFFF), 4'h3, rm};
    endfunction

    function automatic logic [31:0] cmp_word(input logic [15:0] hi, input logic [3:0] rm, input logic dmg);
        return {hi, 9'b010001111, rm, (dmg ? 3'b010 : 3'b000)};
    endfunction

    // one instruction: drive at falling edge, check outputs, then state after edge
    task automatic step(input logic v, input logic [31:0] w, input logic cp,
                        input logic ing, input logic lst, input logic [31:0] tgt);
        logic hit, bad, tk, unp;
        logic [3:0] rm;
        logic [31:0] lnk;
        @(negedge clk);
        valid_i = v; instr_i = w; cond_pass_i = cp;
        grp_inside_i = ing; grp_last_i = lst; rf_data_i = tgt;
        #1;
        if (m_mode) begin
            hit = (w[15:7] == 9'b010001111); rm = w[6:3]; bad = (w[2:0] != 3'b000);
            lnk = (m_pc + 32'd2) | 32'd1;
        end else begin
            hit = (w[27:20] == 8'h12) && (w[7:4] == 4'h3) && (w[31:28] != 4'hF);
            rm = w[3:0]; bad = (w[19:8] != 12'hFFF);
            lnk = m_pc + 32'd4;
        end
        tk  = v && hit && cp;
        unp = v && hit && ((rm == 4'd15) || bad || (m_mode && ing && !lst) ||
                           (!m_mode && tgt[1:0] == 2'b10));
        chk("R12 nothandled", {31'd0, nothandled_o}, {31'd0, v && !hit});
        chk("R7 link write enable", {31'd0, lr_we_o}, {31'd0, tk});
        chk("R8/R9/R10/R11 unpredictable", {31'd0, unpred_o}, {31'd0, unp});
        if (v && hit) chk(m_mode ? "R3 register index" : "R2 register index", {28'd0, rf_addr_o}, {28'd0, rm});
        if (tk) begin
            chk(m_mode ? "R6 compact link" : "R5 wide link", lr_data_o, lnk);
            chk("R4 next pc", next_pc_o, {tgt[31:1], 1'b0});
        end
        @(posedge clk); #1;
        if (tk) begin
            m_pc = {tgt[31:1], 1'b0};
            m_mode = tgt[0];
        end
        chk("R4/R7 pc after edge", pc_o, m_pc);
        chk("R4/R7 mode after edge", {31'd0, mode_o}, {31'd0, m_mode});
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset pc", pc_o, 32'd0);
        chk("R1 reset mode", {31'd0, mode_o}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // directed corner cases, wide mode
        step(1, wide_word(4'hF, 4'd3, 0), 1, 0, 0, 32'h100);         // R2 never-cond not handled
        step(1, wide_word(4'hE, 4'd3, 0), 0, 0, 0, 32'h200);         // R7 cond fail
        step(0, wide_word(4'hE, 4'd3, 0), 1, 0, 0, 32'h200);         // R7 not valid
        step(1, wide_word(4'hE, 4'd15, 0), 1, 0, 0, 32'h400);        // R8
        step(1, wide_word(4'h0, 4'd2, 0), 1, 0, 0, 32'h502);         // R10
        step(1, wide_word(4'h1, 4'd2, 1), 1, 0, 0, 32'h600);         // R11 sbo damaged
        step(1, 32'hDEAD_BEEF, 1, 0, 0, 32'h700);                    // R12
        step(1, wide_word(4'hE, 4'd5, 0), 1, 0, 0, 32'h1001);        // R4 switch to compact
        // directed corner cases, compact mode
        step(1, cmp_word(16'hFFFF, 4'd4, 0), 1, 1, 0, 32'h2001);     // R9 and R3 upper ignored
        step(1, cmp_word(16'h0000, 4'd4, 0), 1, 1, 1, 32'h3001);     // R9 last of group is fine
        step(1, cmp_word(16'h0000, 4'd15, 0), 1, 0, 0, 32'h3101);    // R8
        step(1, cmp_word(16'h0000, 4'd6, 1), 1, 0, 0, 32'h3201);     // R11 sbz damaged
        step(1, cmp_word(16'h0000, 4'd6, 0), 0, 0, 0, 32'h3300);     // R7
        step(1, cmp_word(16'h0000, 4'd6, 0), 1, 0, 0, 32'h3402);     // R6, back to wide

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] w, tgt;
            logic [3:0]  rm;
            int kind;
            kind = $urandom % 8;
            rm = (($urandom % 6) == 0) ? 4'd15 : 4'($urandom % 15);
            tgt = $urandom;
            if (m_mode) w = cmp_word(16'($urandom), rm, kind == 1);
            else        w = wide_word(4'($urandom % 15), rm, kind == 1);
            if (kind == 0) w = $urandom;
            step(($urandom % 8) != 0, w, ($urandom % 4) != 0,
                 ($urandom % 3) == 0, ($urandom % 2) == 0, tgt);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule